// File: doc/BRIEF.md
# Configurable Registered Command Buffer

This block sits between a memory controller and a set of DRAM devices. On every rising clock edge it captures a bank of address and command bits together with three control signals: chip select, termination enable and clock enable. It drives registered copies of them to its outputs. Two static strap inputs pick one of three layouts. The first is a 25-bit one-to-one buffer. The second and third are 14-bit one-to-two fan-outs in which every registered bit drives an A copy and a B copy. The third layout takes termination and clock enable from two data-bit positions and ignores the dedicated pins.

A pair of active-low select inputs can freeze the data outputs when a cycle carries no command. The three control outputs always follow their inputs. An asynchronous active-low reset clears every register and pulls every output low at once. The release of reset passes through a two-stage synchroniser inside the block, so the outputs stay low until the first clean edge after the release. Every output comes from a flop, qualified only by a registered copy of the straps.

Top module: `cmdbuf_reg`

## Requirements
- R1: At a rising edge where reset is released and at least one of `dcs_n` or `csr_n` is low, each live data lane loads its `d_i` bit and shows it on `q_a` after that edge.
- R2: At a rising edge where `dcs_n` and `csr_n` are both high, every data lane keeps its previous value, whatever `d_i` does.
- R3: At every rising edge out of reset, `qcs_n_a` loads `dcs_n`, and `qodt_a`/`qcke_a` load their selected sources. The select gating never holds them.
- R4: With `cfg_fanout` = 0 (one-to-one), all 25 lanes are live and every B output (`q_b`, `qcs_n_b`, `qodt_b`, `qcke_b`) is low. `cfg_alt` has no effect in this layout.
- R5: With `cfg_fanout` = 1, only lanes 0 to 13 are live, `q_a[24:14]` is low, and every B output equals its A twin.
- R6: With `cfg_fanout` = 1 and `cfg_alt` = 1, termination is taken from `d_i[10]` and clock enable from `d_i[13]`. `odt_i` and `cke_i` are ignored, and lanes 10 and 13 read low on both `q_a` and `q_b`. With `cfg_alt` = 0 they come from `odt_i`/`cke_i`.
- R7: While `rst_n` is low, every output is low. A fall of `rst_n` between clock edges clears the outputs without waiting for a clock edge, and it overrides the select hold.
- R8: After `rst_n` rises, the outputs stay low through the first two rising edges and load their inputs at the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_fanout | input | 1 | Strap: 0 one-to-one, 1 one-to-two |
| cfg_alt | input | 1 | Strap: alternate lane mapping in one-to-two |
| dcs_n | input | 1 | Command chip select, active low |
| csr_n | input | 1 | Second select, active low |
| odt_i | input | 1 | Termination enable input |
| cke_i | input | 1 | Clock enable input |
| d_i | input | 25 | Address/command data bits |
| q_a | output | 25 | Registered data, A copy |
| q_b | output | 25 | Registered data, B copy |
| qcs_n_a | output | 1 | Registered chip select, A copy |
| qcs_n_b | output | 1 | Registered chip select, B copy |
| qodt_a | output | 1 | Registered termination enable, A copy |
| qodt_b | output | 1 | Registered termination enable, B copy |
| qcke_a | output | 1 | Registered clock enable, A copy |
| qcke_b | output | 1 | Registered clock enable, B copy |

## Verification
The bench targets runs in which both selects stay high while data and control inputs keep changing. A design that gated the control flops as well would freeze `qcs_n_a` or `qodt_a`, and one that ignored the hold would pass the new data through. In the alternate layout it toggles `odt_i` and `cke_i` against the opposite values on `d_i[10]`/`d_i[13]`, so a wrong source select or a live lane 10 or 13 shows at once. It pulls reset between clock edges and counts the edges after release, which exposes a missing asynchronous clear, a missing synchroniser stage or an extra one.

// File: rtl/cmdbuf_pkg.sv
package cmdbuf_pkg;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'd0,
    MODE_PAIR_A = 2'd1,
    MODE_PAIR_B = 2'd2
  } mode_e;

  // Strap decode: the alternate strap only matters in the fan-out layout.
  function automatic mode_e decode_mode(input logic fanout, input logic alt);
    if (!fanout) return MODE_SINGLE;
    return alt ? MODE_PAIR_B : MODE_PAIR_A;
  endfunction

  // Whether data lane idx carries data in the given layout.
  function automatic logic lane_live(input mode_e m, input int idx, input int pair_w,
                                     input int odt_pos, input int cke_pos);
    case (m)
      MODE_SINGLE: return 1'b1;
      MODE_PAIR_A: return idx < pair_w;
      MODE_PAIR_B: return (idx < pair_w) && (idx != odt_pos) && (idx != cke_pos);
      default:     return 1'b0;
    endcase
  endfunction

  // Data lanes freeze only when both selects are inactive.
  function automatic logic hold_req(input logic sel_a_n, input logic sel_b_n);
    return sel_a_n & sel_b_n;
  endfunction

endpackage

// File: rtl/cmdbuf_rst_sync.sv
module cmdbuf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok
);
  logic stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= 1'b0;
      rst_ok <= 1'b0;
    end else begin
      stage1 <= 1'b1;
      rst_ok <= stage1;
    end
  end
endmodule

// File: rtl/cmdbuf_lane.sv
module cmdbuf_lane (
  input  logic clk,
  input  logic rst_ok,
  input  logic live,
  input  logic hold,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok)     q <= 1'b0;
    else if (!live)  q <= 1'b0;
    else if (!hold)  q <= d;
  end

  // R1: an unheld live lane shows the sampled bit after the edge
  a_r1_lane_load: assert property (@(posedge clk) disable iff (!rst_ok)
    (live && !hold) |=> (q == $past(d)));

  // R2: a held lane keeps its value
  a_r2_lane_hold: assert property (@(posedge clk) disable iff (!rst_ok)
    (live && hold) |=> $stable(q));

  // R5: a lane outside the active layout reads low
  a_r5_lane_dead: assert property (@(posedge clk) disable iff (!rst_ok)
    !live |=> !q);
endmodule

// File: rtl/cmdbuf_ctrl.sv
module cmdbuf_ctrl
  import cmdbuf_pkg::*;
(
  input  logic  clk,
  input  logic  rst_ok,
  input  mode_e mode,
  input  logic  dcs_n,
  input  logic  odt_pin,
  input  logic  cke_pin,
  input  logic  odt_lane,
  input  logic  cke_lane,
  output logic  cs_q,
  output logic  odt_q,
  output logic  cke_q
);
  logic odt_src, cke_src;

  always_comb begin
    odt_src = (mode == MODE_PAIR_B) ? odt_lane : odt_pin;
    cke_src = (mode == MODE_PAIR_B) ? cke_lane : cke_pin;
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      cs_q  <= 1'b0;
      odt_q <= 1'b0;
      cke_q <= 1'b0;
    end else begin
      cs_q  <= dcs_n;
      odt_q <= odt_src;
      cke_q <= cke_src;
    end
  end

  // R3: chip select is never held
  a_r3_cs_follows: assert property (@(posedge clk) disable iff (!rst_ok)
    rst_ok |=> (cs_q == $past(dcs_n)));

  // R6: alternate layout takes termination and clock enable from data lanes
  a_r6_alt_source: assert property (@(posedge clk) disable iff (!rst_ok)
    (mode == MODE_PAIR_B) |=> (odt_q == $past(odt_lane) && cke_q == $past(cke_lane)));

  // R3: primary layouts take them from the dedicated pins
  a_r3_pin_source: assert property (@(posedge clk) disable iff (!rst_ok)
    (mode != MODE_PAIR_B) |=> (odt_q == $past(odt_pin) && cke_q == $past(cke_pin)));
endmodule

// File: rtl/cmdbuf_reg.sv
module cmdbuf_reg
  import cmdbuf_pkg::*;
#(
  parameter int D_W         = 25,
  parameter int PAIR_W      = 14,
  parameter int ALT_ODT_IDX = 10,
  parameter int ALT_CKE_IDX = 13
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_fanout,
  input  logic           cfg_alt,
  input  logic           dcs_n,
  input  logic           csr_n,
  input  logic           odt_i,
  input  logic           cke_i,
  input  logic [D_W-1:0] d_i,
  output logic [D_W-1:0] q_a,
  output logic [D_W-1:0] q_b,
  output logic           qcs_n_a,
  output logic           qcs_n_b,
  output logic           qodt_a,
  output logic           qodt_b,
  output logic           qcke_a,
  output logic           qcke_b
);
  mode_e          mode_q;
  logic           rst_ok;
  logic           hold;
  logic           b_en;
  logic [D_W-1:0] lane_live_v;
  logic [D_W-1:0] q_core;
  logic           cs_q, odt_q, cke_q;

  // Static straps are re-registered every edge; they settle during reset.
  always_ff @(posedge clk) mode_q <= decode_mode(cfg_fanout, cfg_alt);

  assign hold = hold_req(dcs_n, csr_n);
  assign b_en = (mode_q != MODE_SINGLE);

  cmdbuf_rst_sync u_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ok (rst_ok)
  );

  for (genvar i = 0; i < D_W; i++) begin : g_lane
    assign lane_live_v[i] = lane_live(mode_q, i, PAIR_W, ALT_ODT_IDX, ALT_CKE_IDX);
    cmdbuf_lane u_lane (
      .clk    (clk),
      .rst_ok (rst_ok),
      .live   (lane_live_v[i]),
      .hold   (hold),
      .d      (d_i[i]),
      .q      (q_core[i])
    );
  end

  cmdbuf_ctrl u_ctrl (
    .clk      (clk),
    .rst_ok   (rst_ok),
    .mode     (mode_q),
    .dcs_n    (dcs_n),
    .odt_pin  (odt_i),
    .cke_pin  (cke_i),
    .odt_lane (d_i[ALT_ODT_IDX]),
    .cke_lane (d_i[ALT_CKE_IDX]),
    .cs_q     (cs_q),
    .odt_q    (odt_q),
    .cke_q    (cke_q)
  );

  assign q_a     = q_core;
  assign q_b     = b_en ? q_core : '0;
  assign qcs_n_a = cs_q;
  assign qodt_a  = odt_q;
  assign qcke_a  = cke_q;
  assign qcs_n_b = b_en & cs_q;
  assign qodt_b  = b_en & odt_q;
  assign qcke_b  = b_en & cke_q;

  // R4: one-to-one strap leaves every B output low
  a_r4_b_quiet: assert property (@(posedge clk) disable iff (!rst_ok)
    (!cfg_fanout && !$changed(cfg_fanout)) |=>
      (q_b == '0 && !qcs_n_b && !qodt_b && !qcke_b));

  // R7: reset pulls every output low
  a_r7_reset_low: assert property (@(negedge clk)
    !rst_n |-> (q_a == '0 && q_b == '0 && !qcs_n_a && !qcs_n_b &&
                !qodt_a && !qodt_b && !qcke_a && !qcke_b));

  // R8: the edge on which the synchroniser releases still leaves outputs low
  a_r8_release_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_ok) |-> (q_a == '0 && !qcs_n_a && !qodt_a && !qcke_a));
endmodule

// File: tb/cmdbuf_reg_tb.sv
`timescale 1ns/100ps
module cmdbuf_reg_tb;
  localparam int W = 25;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_fanout = 1'b0, cfg_alt = 1'b0;
  logic         dcs_n = 1'b1, csr_n = 1'b1, odt_i = 1'b0, cke_i = 1'b0;
  logic [W-1:0] d_i = '0;
  logic [W-1:0] q_a, q_b;
  logic         qcs_n_a, qcs_n_b, qodt_a, qodt_b, qcke_a, qcke_b;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // model state
  logic [W-1:0] m_reg;
  logic         m_cs, m_odt, m_cke;
  int           m_sync;

  always #2 clk = ~clk;

  cmdbuf_reg u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_fanout(cfg_fanout), .cfg_alt(cfg_alt),
    .dcs_n(dcs_n), .csr_n(csr_n), .odt_i(odt_i), .cke_i(cke_i), .d_i(d_i),
    .q_a(q_a), .q_b(q_b), .qcs_n_a(qcs_n_a), .qcs_n_b(qcs_n_b),
    .qodt_a(qodt_a), .qodt_b(qodt_b), .qcke_a(qcke_a), .qcke_b(qcke_b)
  );

  function automatic logic [W-1:0] live_mask(input logic fan, input logic alt);
    if (!fan) return {W{1'b1}};
    if (!alt) return 25'h0003FFF;
    return 25'h0001BFF;  // lanes 10 and 13 carry control in alternate layout
  endfunction

  function automatic logic [W-1:0] exp_qa();
    return m_reg & live_mask(cfg_fanout, cfg_alt);
  endfunction

  task automatic chk(input string req, input string what, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    logic [W-1:0] ea;
    string rb, rc;
    ea = exp_qa();
    rb = cfg_fanout ? "R5" : "R4";
    rc = (cfg_fanout && cfg_alt) ? "R6" : "R3";
    chk(tag, "q_a", q_a, ea);
    chk(rb, "q_b", q_b, cfg_fanout ? ea : '0);
    chk(rc, "ctrl_a", {22'd0, qcs_n_a, qodt_a, qcke_a}, {22'd0, m_cs, m_odt, m_cke});
    chk(rb, "ctrl_b", {22'd0, qcs_n_b, qodt_b, qcke_b},
        cfg_fanout ? {22'd0, m_cs, m_odt, m_cke} : '0);
  endtask

  // one clock: model follows the edge, outputs compared at the next falling edge
  task automatic tick(input string tag);
    @(posedge clk);
    if (!rst_n) begin
      m_reg = '0; m_cs = 0; m_odt = 0; m_cke = 0; m_sync = 0;
    end else begin
      if (m_sync >= 2) begin
        if (!(dcs_n && csr_n)) m_reg = d_i;
        m_cs  = dcs_n;
        m_odt = (cfg_fanout && cfg_alt) ? d_i[10] : odt_i;
        m_cke = (cfg_fanout && cfg_alt) ? d_i[13] : cke_i;
      end
      if (m_sync < 2) m_sync++;
    end
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic randomize_inputs(input int hold_pct);
    d_i   = W'($urandom);
    odt_i = 1'($urandom);
    cke_i = 1'($urandom);
    if (($urandom % 100) < hold_pct) begin
      dcs_n = 1'b1; csr_n = 1'b1;
    end else begin
      dcs_n = 1'($urandom);
      csr_n = dcs_n ? 1'b0 : 1'($urandom);
    end
  endtask

  task automatic enter_reset(input logic fan, input logic alt);
    @(negedge clk);
    #1 rst_n = 1'b0;
    #0.5;
    m_reg = '0; m_cs = 0; m_odt = 0; m_cke = 0; m_sync = 0;
    // R7: cleared before any clock edge
    chk("R7", "async clear q_a", q_a, '0);
    chk("R7", "async clear ctrl", {22'd0, qcs_n_a, qodt_a, qcke_a}, '0);
    cfg_fanout = fan; cfg_alt = alt;
    for (int k = 0; k < 3; k++) begin
      randomize_inputs(0);
      tick("R7");
    end
  endtask

  task automatic leave_reset();
    d_i = 25'h1FFFFFF; dcs_n = 1'b1; csr_n = 1'b0; odt_i = 1'b1; cke_i = 1'b1;
    rst_n = 1'b1;
    tick("R8");
    tick("R8");
    chk("R8", "low after two edges", q_a, '0);
    tick("R8");
    chk("R8", "loaded at third edge", q_a, live_mask(cfg_fanout, cfg_alt));
  endtask

  task automatic run_mode(input logic fan, input logic alt, input int cycles);
    enter_reset(fan, alt);
    leave_reset();
    // directed: hold run with changing data and controls (R2, R3)
    dcs_n = 1'b0; csr_n = 1'b1; d_i = 25'h0AAAAAA; tick("R1");
    for (int k = 0; k < 4; k++) begin
      dcs_n = 1'b1; csr_n = 1'b1; d_i = ~d_i; odt_i = ~odt_i; cke_i = ~cke_i;
      tick("R2");
    end
    // directed: alternate sources set against pins (R6)
    csr_n = 1'b0; d_i = 25'h0002400; odt_i = 1'b0; cke_i = 1'b0; tick("R6");
    d_i = 25'h0000000; odt_i = 1'b1; cke_i = 1'b1; tick("R6");
    for (int k = 0; k < cycles; k++) begin
      randomize_inputs(35);
      tick("R1");
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    m_reg = '0; m_cs = 0; m_odt = 0; m_cke = 0; m_sync = 0;
    repeat (3) @(negedge clk);
    // reset state
    chk("R7", "reset q_a", q_a, '0);
    chk("R7", "reset q_b", q_b, '0);
    run_mode(1'b0, 1'b0, 150);
    run_mode(1'b1, 1'b0, 150);
    run_mode(1'b1, 1'b1, 150);
    // R4: alternate strap ignored in one-to-one layout
    run_mode(1'b0, 1'b1, 60);
    // R7: reset mid-run while selects hold, outputs still cleared
    dcs_n = 1'b1; csr_n = 1'b1;
    enter_reset(1'b1, 1'b0);
    finish_run();
  end

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule